// File: doc/BRIEF.md
# Memory checksum accumulator

This block forms the 16-bit checksum of a small program memory image. The memory words arrive one per cycle, each with its address. The host first pulses `start`. It then streams the words in any order and marks the final one with `word_last`. The low bits of the configuration word and the low nibbles of the four user ID words stay steady on their own inputs for the whole run. `large_sel` chooses the memory size: a 512-word image when low, a 1024-word image when high.

Bit 3 of the configuration word selects the rule. When that bit is 1, the image is unprotected. The block then sums every user word except the top one, and adds the configuration field. When that bit is 0, the image is protected. The block then sums only the first 64 words, and adds the configuration field plus one 16-bit value built from the four ID nibbles. The addition wraps at 16 bits. One cycle after the final word, `done` pulses and `checksum` holds the result. The result stays put until the next `start`.

Top module: `cks_accum`

## Requirements
- R1: A `start` pulse clears the sum, so `checksum` reads 0x0000 on the following cycle. A word offered in the same cycle as `start` is not added.
- R2: The sum is 16 bits wide. Any carry out of bit 15 is lost.
- R3: With protection off, the words at addresses 0x000 up to the top user address minus one are summed. That bound is 0x1FE when `large_sel`=0 and 0x3FE when `large_sel`=1.
- R4: With protection on, only the words at addresses 0x000 to 0x03F are summed, for either size.
- R5: The accepted final word also adds `cfg_word` (bits [4:0], zero-extended to 16 bits).
- R6: With protection on, the final word also adds the ID value {uid0, uid1, uid2, uid3}, with uid0 in bits [15:12]. With protection off, no ID value is added.
- R7: Protection is on exactly when `cfg_word[3]` is 0.
- R8: A word whose address is outside the selected range leaves the sum unchanged. This covers 0x1FF and 0x200 and above when `large_sel`=0, and 0x3FF when `large_sel`=1.
- R9: Between the final word and the next `start`, offered words are ignored and `checksum` does not change.
- R10: `done` is high for exactly one cycle, the cycle after the final word is accepted. `checksum` holds the result from then until the next `start`.
- R11: Summing every user word as 0xFFF, with `cfg_word`=0x1F, gives 0xEE20 when `large_sel`=0 and 0xEC20 when `large_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the sum and opens a run |
| word_valid | input | 1 | A memory word is offered this cycle |
| word_last | input | 1 | The offered word is the final one of the run |
| word_addr | input | 10 | Address of the offered word |
| word_data | input | 12 | Offered memory word |
| cfg_word | input | 5 | Defined bits of the configuration word; bit 3 low means protected |
| uid0 | input | 4 | Low nibble of user ID 0 |
| uid1 | input | 4 | Low nibble of user ID 1 |
| uid2 | input | 4 | Low nibble of user ID 2 |
| uid3 | input | 4 | Low nibble of user ID 3 |
| large_sel | input | 1 | 0: 512 user words, 1: 1024 user words |
| done | output | 1 | One-cycle pulse when the checksum is ready |
| checksum | output | 16 | Running sum; the final result from `done` onward |

## Verification
The bench streams erased images of both sizes and compares the totals with the two known constants. A range bound that is off by one, or that includes the top word, gives a different total. Directed runs present words at 0x03F and 0x040 with protection on, and at 0x1FF and 0x200 in the small image. A wrong window compare would add one of these words. IDs 1, 2, 3, 4 must pack to 0x1234; reversed nibble order would give 0x4321. Further runs use random addresses, data, configuration and IDs. They also offer words while idle and a word in the same cycle as `start`, which a design with loose run control would add to the sum.

// File: rtl/cks_pkg.sv
package cks_pkg;
    localparam int unsigned SUM_W = 16;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [SUM_W-1:0] acc;
    } cks_state_t;
endpackage

// File: rtl/cks_window.sv
module cks_window #(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned SMALL_WORDS = 512,
    parameter int unsigned LARGE_WORDS = 1024,
    parameter int unsigned PROT_WORDS  = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              large_sel,
    input  logic              protect,
    output logic              keep
);
    localparam int unsigned LW = ADDR_W + 1;
    localparam logic [LW-1:0] LIM_PROT  = LW'(PROT_WORDS);
    localparam logic [LW-1:0] LIM_SMALL = LW'(SMALL_WORDS - 1);
    localparam logic [LW-1:0] LIM_LARGE = LW'(LARGE_WORDS - 1);

    logic [LW-1:0] limit;

    always_comb begin
        if (protect)        limit = LIM_PROT;
        else if (large_sel) limit = LIM_LARGE;
        else                limit = LIM_SMALL;
        keep = ({1'b0, addr} < limit);
    end
endmodule

// File: rtl/cks_id_pack.sv
module cks_id_pack #(
    parameter int unsigned NIB_W    = 4,
    parameter int unsigned ID_COUNT = 4,
    parameter int unsigned OUT_W    = 16
) (
    input  logic [ID_COUNT*NIB_W-1:0] ids,
    output logic [OUT_W-1:0]          packed_val
);
    localparam int unsigned PK_W = ID_COUNT * NIB_W;

    logic [PK_W-1:0] nibs;

    for (genvar k = 0; k < ID_COUNT; k++) begin : g_nib
        assign nibs[(ID_COUNT-1-k)*NIB_W +: NIB_W] = ids[k*NIB_W +: NIB_W];
    end

    assign packed_val = OUT_W'(nibs);
endmodule

// File: rtl/cks_accum.sv
module cks_accum
    import cks_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned WORD_W      = 12,
    parameter int unsigned CFG_W       = 5,
    parameter int unsigned CP_BIT      = 3,
    parameter int unsigned NIB_W       = 4,
    parameter int unsigned SMALL_WORDS = 512,
    parameter int unsigned LARGE_WORDS = 1024,
    parameter int unsigned PROT_WORDS  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              word_valid,
    input  logic              word_last,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [WORD_W-1:0] word_data,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [NIB_W-1:0]  uid0,
    input  logic [NIB_W-1:0]  uid1,
    input  logic [NIB_W-1:0]  uid2,
    input  logic [NIB_W-1:0]  uid3,
    input  logic              large_sel,
    output logic              done,
    output logic [SUM_W-1:0]  checksum
);
    localparam int unsigned ID_COUNT = 4;

    cks_state_t       state_d, state_q;
    logic             protect;
    logic             keep;
    logic [SUM_W-1:0] id_val;
    logic [SUM_W-1:0] addend;
    logic [SUM_W-1:0] tail;

    assign protect = ~cfg_word[CP_BIT];

    cks_window #(
        .ADDR_W     (ADDR_W),
        .SMALL_WORDS(SMALL_WORDS),
        .LARGE_WORDS(LARGE_WORDS),
        .PROT_WORDS (PROT_WORDS)
    ) u_window (
        .addr     (word_addr),
        .large_sel(large_sel),
        .protect  (protect),
        .keep     (keep)
    );

    cks_id_pack #(
        .NIB_W   (NIB_W),
        .ID_COUNT(ID_COUNT),
        .OUT_W   (SUM_W)
    ) u_id_pack (
        .ids       ({uid3, uid2, uid1, uid0}),
        .packed_val(id_val)
    );

    always_comb begin
        addend  = keep ? SUM_W'(word_data) : '0;
        tail    = SUM_W'(cfg_word) + (protect ? id_val : '0);
        state_d = state_q;
        state_d.done = 1'b0;
        if (start) begin
            state_d.acc  = '0;
            state_d.busy = 1'b1;
        end else if (state_q.busy && word_valid) begin
            if (word_last) begin
                state_d.acc  = state_q.acc + addend + tail;
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end else begin
                state_d.acc  = state_q.acc + addend;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign done     = state_q.done;
    assign checksum = state_q.acc;

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (checksum == '0 && !done));

    assert_skip_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_last && !keep && !start) |=> $stable(checksum));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.busy && !start) |=> $stable(checksum));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(word_valid && word_last && state_q.busy && !start));
endmodule

// File: tb/cks_accum_test.sv
module cks_accum_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        word_valid = 1'b0;
    logic        word_last = 1'b0;
    logic [9:0]  word_addr = '0;
    logic [11:0] word_data = '0;
    logic [4:0]  cfg_word = 5'h1F;
    logic [3:0]  uid0 = '0, uid1 = '0, uid2 = '0, uid3 = '0;
    logic        large_sel = 1'b0;
    logic        done;
    logic [15:0] checksum;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    logic [15:0] exp_sum;

    always #4 clk = ~clk;

    cks_accum uut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
        .word_last(word_last), .word_addr(word_addr), .word_data(word_data),
        .cfg_word(cfg_word), .uid0(uid0), .uid1(uid1), .uid2(uid2), .uid3(uid3),
        .large_sel(large_sel), .done(done), .checksum(checksum)
    );

    function automatic bit in_range(input logic [9:0] a, input bit big, input bit prot);
        if (prot) return a < 10'd64;
        return big ? (a < 10'd1023) : (a < 10'd511);
    endfunction

    function automatic logic [15:0] tail_val(input logic [4:0] cfg, input logic [3:0] i0,
                                             input logic [3:0] i1, input logic [3:0] i2,
                                             input logic [3:0] i3);
        logic [15:0] t;
        t = {11'd0, cfg};
        if (!cfg[3]) t = t + {i0, i1, i2, i3};
        return t;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(checksum == 16'h0 && !done, "R1 start clears", checksum, 16'h0);
        exp_sum = 16'h0;
    endtask

    task automatic send(input logic [9:0] a, input logic [11:0] d, input bit last);
        word_valid = 1'b1; word_addr = a; word_data = d; word_last = last;
        if (in_range(a, large_sel, !cfg_word[3])) exp_sum = exp_sum + {4'd0, d};
        if (last) exp_sum = exp_sum + tail_val(cfg_word, uid0, uid1, uid2, uid3);
        @(negedge clk);
        word_valid = 1'b0; word_last = 1'b0;
    endtask

    task automatic finish_checks(input string tag);
        logic [15:0] held;
        check(done == 1'b1, {tag, " R10 done pulse"}, {15'd0, done}, 16'd1);
        check(checksum == exp_sum, tag, checksum, exp_sum);
        held = checksum;
        word_valid = 1'b1; word_addr = 10'd0; word_data = 12'hABC; word_last = 1'b1;
        @(negedge clk);
        word_valid = 1'b0; word_last = 1'b0;
        check(done == 1'b0, {tag, " R10 done falls"}, {15'd0, done}, 16'd0);
        check(checksum == held, {tag, " R9 idle hold"}, checksum, held);
    endtask

    task automatic erased_run(input bit big, input logic [15:0] golden, input string tag);
        int unsigned n;
        large_sel = big; cfg_word = 5'h1F;
        n = big ? 1024 : 512;
        do_start();
        for (int unsigned a = 0; a < n; a++) send(10'(a), 12'hFFF, a == n - 1);
        check(exp_sum == golden, {tag, " bench model"}, exp_sum, golden);
        finish_checks(tag);
    endtask

    initial begin
        #(200000 * 8);
        n_fails++;
        $display("FAIL watchdog actual=0x%04h expected=0x%04h", checksum, 16'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(checksum == 16'h0 && done == 1'b0, "reset state", checksum, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 R3 R2: erased images of both sizes, sum wraps
        erased_run(1'b0, 16'hEE20, "R11 small erased");
        erased_run(1'b1, 16'hEC20, "R11 large erased");

        // R4 R6 R7: protected window edges and ID packing 1,2,3,4
        large_sel = 1'b1; cfg_word = 5'h17;
        uid0 = 4'h1; uid1 = 4'h2; uid2 = 4'h3; uid3 = 4'h4;
        do_start();
        send(10'h03F, 12'h100, 1'b0);
        send(10'h040, 12'h800, 1'b0);
        send(10'h000, 12'h001, 1'b1);
        check(checksum == 16'h1234 + 16'h0017 + 16'h0101, "R6 R4 protected packing",
              checksum, 16'h134C);
        finish_checks("R4 protected");

        // R8 R3 R5: small image top word and upper half skipped, protection off
        large_sel = 1'b0; cfg_word = 5'h0A ^ 5'h08 ^ 5'h08;
        cfg_word = 5'h0F;
        do_start();
        send(10'h1FE, 12'h010, 1'b0);
        send(10'h1FF, 12'h020, 1'b0);
        send(10'h200, 12'h040, 1'b0);
        send(10'h3FE, 12'h080, 1'b1);
        check(checksum == 16'h001F, "R8 R5 skipped words", checksum, 16'h001F);
        finish_checks("R8 small range");

        // R1: word in the same cycle as start is not added
        cfg_word = 5'h1F;
        start = 1'b1; word_valid = 1'b1; word_addr = 10'd1; word_data = 12'h777;
        @(negedge clk);
        start = 1'b0; word_valid = 1'b0;
        check(checksum == 16'h0, "R1 start priority", checksum, 16'h0);
        exp_sum = 16'h0;
        send(10'd2, 12'h005, 1'b1);
        finish_checks("R1 start priority run");

        // R2 R3 R4 R5 R6 R7 R8: random images
        for (int r = 0; r < 24; r++) begin
            int unsigned cnt;
            large_sel = 1'($urandom);
            cfg_word  = 5'($urandom);
            uid0 = 4'($urandom); uid1 = 4'($urandom);
            uid2 = 4'($urandom); uid3 = 4'($urandom);
            cnt = 1 + ($urandom % 200);
            do_start();
            for (int unsigned k = 0; k < cnt; k++) begin
                logic [9:0] a;
                a = (($urandom % 4) == 0) ? 10'($urandom % 80) : 10'($urandom);
                send(a, 12'($urandom), k == cnt - 1);
            end
            finish_checks("R7 random image");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule